// File: doc/BRIEF.md
# Packed Complex Vector Multiply-Accumulate Engine

This block is a streaming fixed-point engine for matrices of complex numbers held in memory words. Each word carries PF complex elements (PF = 1, 2 or 4), and all PF lanes are computed in the same cycle. The engine can scale a row by a complex factor, multiply two rows element by element, or add two rows element by element. It can also fold all lane results of a row into a single complex value, emitted once at the end of the row.

A beat is one word from each operand stream plus a per-row factor and a row-end flag. Beats arrive on a valid/ready input and results leave on a valid/ready output. The configuration inputs are held steady while a stream is running. Full precision is kept internally. One configurable shift, one rounding choice and one overflow choice reduce each result to 8+8 bits at the output.

Top module: `cvmac_engine`

## Requirements
- R1: Element layout: each 16-bit complex element holds an 8-bit signed real part in bits [7:0] and an 8-bit signed imaginary part in bits [15:8]; lane k occupies bits [16k+15:16k] of a word. With cfg_op = 0 (scale), lane k of the result is Q(alpha·a_k), where re = αr·ar − αi·ai and im = αr·ai + αi·ar.
- R2: With cfg_op = 1 (product), lane k of the result is Q(a_k·b_k), using the same complex product formula as R1.
- R3: With cfg_op = 2 (sum), lane k of the result is Q(a_k + b_k), adding the real parts and the imaginary parts separately.
- R4: With cfg_reduce = 1, beats that are not the last beat of a row produce no output. The beat flagged in_last produces exactly one word with out_last = 1. That word carries Q of the full-precision sum of every lane result in the row, in lane 0, and all other lanes are zero.
- R5: With cfg_reduce = 0, every accepted beat produces one output word, and out_last copies that beat's in_last.
- R6: With cfg_alpha_ind = 0, alpha is cfg_alpha on every row. With cfg_alpha_ind = 1, alpha is the in_alpha value presented on the first beat of each row, and in_alpha on the later beats of that row has no effect.
- R7: With cfg_same = 1, the second operand is taken from in_a and in_b has no effect.
- R8: Q first shifts the value right arithmetically by cfg_shift. With cfg_round = 0 this truncates toward minus infinity. With cfg_round = 1, 2^(cfg_shift−1) is added before the shift (round half up), and nothing is added when cfg_shift = 0.
- R9: With cfg_sat = 0, Q keeps the low 8 bits of the shifted value (two's-complement wrap). With cfg_sat = 1, Q clamps the shifted value to the range −128 to 127.
- R10: While out_valid = 1 and out_ready = 0, in_ready is low, and out_data and out_last hold their values.
- R11: After reset, out_valid is low, the row accumulator is empty, and the next beat starts a new row.
- R12: With out_ready held high, one beat is accepted every cycle, and its result appears on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_op | input | 2 | Operation: 0 scale, 1 product, 2 sum |
| cfg_reduce | input | 1 | Accumulate each row into one result |
| cfg_alpha_ind | input | 1 | Take alpha from in_alpha once per row |
| cfg_same | input | 1 | Use in_a as both operands |
| cfg_alpha | input | 2*EW (16) | Immediate complex scale factor |
| cfg_round | input | 1 | 0 truncate, 1 round half up |
| cfg_sat | input | 1 | 0 wrap, 1 saturate |
| cfg_shift | input | SH_W (5) | Output right shift |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_a | input | PF*2*EW (64) | First operand word |
| in_b | input | PF*2*EW (64) | Second operand word |
| in_alpha | input | 2*EW (16) | Per-row complex factor |
| in_last | input | 1 | Marks the final beat of a row |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | PF*2*EW (64) | Result word |
| out_last | output | 1 | Result closes a row |

## Verification
A stale or corrupted accumulator shows up only on the reduced word at the end of a row. Every row therefore ends in a check on its single output, and the non-last beats are checked for silence. A wrong row-start flag makes indirect alpha pick up a later beat's factor, which shows in the first result that uses it. A lost stall shows as an output word that changes, or as a beat that is accepted while out_ready is low, within one cycle.

// File: rtl/cvmac_pkg.sv
package cvmac_pkg;
   typedef enum logic [1:0] {
      OP_SCALE = 2'd0,
      OP_PROD  = 2'd1,
      OP_SUM   = 2'd2
   } cvmac_op_e;
endpackage

// File: rtl/cvmac_lane.sv
// One complex lane: full-precision scale, product or sum.
module cvmac_lane
   import cvmac_pkg::*;
#(
   parameter int EW = 8,
   parameter int PW = 2 * EW + 1
) (
   input  cvmac_op_e               op,
   input  logic [2*EW-1:0]         a,
   input  logic [2*EW-1:0]         b,
   input  logic [2*EW-1:0]         alpha,
   output logic signed [PW-1:0]    res_re,
   output logic signed [PW-1:0]    res_im
);
   logic signed [PW-1:0] ar, ai, br, bi, xr, xi, yr, yi;
   logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;

   always_comb begin
      ar = {{(PW-EW){a[EW-1]}},     a[EW-1:0]};
      ai = {{(PW-EW){a[2*EW-1]}},   a[2*EW-1:EW]};
      br = {{(PW-EW){b[EW-1]}},     b[EW-1:0]};
      bi = {{(PW-EW){b[2*EW-1]}},   b[2*EW-1:EW]};
      if (op == OP_SCALE) begin
         xr = {{(PW-EW){alpha[EW-1]}},   alpha[EW-1:0]};
         xi = {{(PW-EW){alpha[2*EW-1]}}, alpha[2*EW-1:EW]};
         yr = ar;
         yi = ai;
      end else begin
         xr = ar;
         xi = ai;
         yr = br;
         yi = bi;
      end
      p_rr = xr * yr;
      p_ii = xi * yi;
      p_ri = xr * yi;
      p_ir = xi * yr;
      case (op)
         OP_SCALE, OP_PROD: begin
            res_re = p_rr - p_ii;
            res_im = p_ri + p_ir;
         end
         default: begin
            res_re = ar + br;
            res_im = ai + bi;
         end
      endcase
   end
endmodule

// File: rtl/cvmac_quant.sv
// Shift, optional half-up rounding, then wrap or clamp to EW bits.
module cvmac_quant #(
   parameter int IW   = 17,
   parameter int EW   = 8,
   parameter int SH_W = 5
) (
   input  logic signed [IW-1:0] val,
   input  logic [SH_W-1:0]      shift,
   input  logic                 rnd,
   input  logic                 sat,
   output logic [EW-1:0]        q
);
   localparam logic signed [IW:0] QMAX = (IW+1)'((1 << (EW - 1)) - 1);
   localparam logic signed [IW:0] QMIN = -QMAX - (IW+1)'(1);

   logic        [IW:0] bias;
   logic signed [IW:0] ext, biased, shd;

   generate
      if (IW <= EW) begin : g_bad_width
         $error("cvmac_quant: input must be wider than output");
      end
   endgenerate

   always_comb begin
      ext    = {val[IW-1], val};
      bias   = (rnd && shift != '0) ? ((IW+1)'(1) << (shift - 1'b1)) : '0;
      biased = ext + $signed(bias);
      shd    = biased >>> shift;
      if (sat && shd > QMAX)      q = QMAX[EW-1:0];
      else if (sat && shd < QMIN) q = QMIN[EW-1:0];
      else                        q = shd[EW-1:0];
   end
endmodule

// File: rtl/cvmac_lanesum.sv
// Adds N packed signed lane values into one wider sum.
module cvmac_lanesum #(
   parameter int N  = 4,
   parameter int IW = 17,
   parameter int OW = 24
) (
   input  logic [N*IW-1:0]      lanes,
   output logic signed [OW-1:0] total
);
   generate
      if (OW < IW) begin : g_bad_width
         $error("cvmac_lanesum: output narrower than input");
      end
   endgenerate

   always_comb begin
      total = '0;
      for (int k = 0; k < N; k++) begin
         total = total + OW'($signed(lanes[k*IW +: IW]));
      end
   end
endmodule

// File: rtl/cvmac_engine.sv
// Packed complex multiply/add engine with optional row reduction.
module cvmac_engine
   import cvmac_pkg::*;
#(
   parameter int PF      = 4,
   parameter int EW      = 8,
   parameter int ROW_MAX = 16,
   localparam int CW     = 2 * EW,
   localparam int DW     = PF * CW,
   localparam int PW     = 2 * EW + 1,
   localparam int ACC_W  = PW + $clog2(PF * ROW_MAX) + 1,
   localparam int SH_W   = $clog2(ACC_W + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_op,
   input  logic            cfg_reduce,
   input  logic            cfg_alpha_ind,
   input  logic            cfg_same,
   input  logic [CW-1:0]   cfg_alpha,
   input  logic            cfg_round,
   input  logic            cfg_sat,
   input  logic [SH_W-1:0] cfg_shift,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [DW-1:0]   in_a,
   input  logic [DW-1:0]   in_b,
   input  logic [CW-1:0]   in_alpha,
   input  logic            in_last,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [DW-1:0]   out_data,
   output logic            out_last
);
   generate
      if (!(PF == 1 || PF == 2 || PF == 4)) begin : g_bad_pf
         $error("cvmac_engine: PF must be 1, 2 or 4");
      end
      if (ROW_MAX < 1 || EW < 2) begin : g_bad_cfg
         $error("cvmac_engine: ROW_MAX and EW out of range");
      end
   endgenerate

   cvmac_op_e op;
   logic      accept, row_first;
   logic [CW-1:0] alpha_hold, alpha_eff;
   logic [DW-1:0] b_eff, lane_word, red_word;
   logic [PF*PW-1:0] re_flat, im_flat;
   logic signed [ACC_W-1:0] beat_re, beat_im, acc_re, acc_im, tot_re, tot_im;
   logic [EW-1:0] red_re_q, red_im_q;

   assign op        = cvmac_op_e'(cfg_op);
   assign in_ready  = !out_valid || out_ready;
   assign accept    = in_valid && in_ready;
   assign b_eff     = cfg_same ? in_a : in_b;
   assign alpha_eff = !cfg_alpha_ind ? cfg_alpha
                    : (row_first ? in_alpha : alpha_hold);

   // Parallel lanes: arithmetic plus per-lane quantisation.
   for (genvar k = 0; k < PF; k++) begin : g_lane
      logic signed [PW-1:0] l_re, l_im;
      logic [EW-1:0]        q_re, q_im;

      cvmac_lane #(.EW(EW), .PW(PW)) u_lane (
         .op    (op),
         .a     (in_a[k*CW +: CW]),
         .b     (b_eff[k*CW +: CW]),
         .alpha (alpha_eff),
         .res_re(l_re),
         .res_im(l_im)
      );

      cvmac_quant #(.IW(PW), .EW(EW), .SH_W(SH_W)) u_q_re (
         .val(l_re), .shift(cfg_shift), .rnd(cfg_round), .sat(cfg_sat), .q(q_re)
      );
      cvmac_quant #(.IW(PW), .EW(EW), .SH_W(SH_W)) u_q_im (
         .val(l_im), .shift(cfg_shift), .rnd(cfg_round), .sat(cfg_sat), .q(q_im)
      );

      assign re_flat[k*PW +: PW]   = l_re;
      assign im_flat[k*PW +: PW]   = l_im;
      assign lane_word[k*CW +: CW] = {q_im, q_re};
   end

   // Row reduction path.
   cvmac_lanesum #(.N(PF), .IW(PW), .OW(ACC_W)) u_sum_re (
      .lanes(re_flat), .total(beat_re)
   );
   cvmac_lanesum #(.N(PF), .IW(PW), .OW(ACC_W)) u_sum_im (
      .lanes(im_flat), .total(beat_im)
   );

   assign tot_re = acc_re + beat_re;
   assign tot_im = acc_im + beat_im;

   cvmac_quant #(.IW(ACC_W), .EW(EW), .SH_W(SH_W)) u_q_red_re (
      .val(tot_re), .shift(cfg_shift), .rnd(cfg_round), .sat(cfg_sat), .q(red_re_q)
   );
   cvmac_quant #(.IW(ACC_W), .EW(EW), .SH_W(SH_W)) u_q_red_im (
      .val(tot_im), .shift(cfg_shift), .rnd(cfg_round), .sat(cfg_sat), .q(red_im_q)
   );

   always_comb begin
      red_word          = '0;
      red_word[CW-1:0]  = {red_im_q, red_re_q};
   end

   // Row tracking and alpha capture.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_first  <= 1'b1;
         alpha_hold <= '0;
      end else if (accept) begin
         row_first <= in_last;
         if (row_first) alpha_hold <= in_alpha;
      end
   end

   // Accumulator and output register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_re    <= '0;
         acc_im    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (accept) begin
         if (!cfg_reduce) begin
            out_valid <= 1'b1;
            out_data  <= lane_word;
            out_last  <= in_last;
         end else if (in_last) begin
            out_valid <= 1'b1;
            out_data  <= red_word;
            out_last  <= 1'b1;
            acc_re    <= '0;
            acc_im    <= '0;
         end else begin
            out_valid <= 1'b0;
            acc_re    <= tot_re;
            acc_im    <= tot_im;
         end
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cvmac_engine_chk.sv
// Protocol checker bound to the engine.
module cvmac_engine_chk #(
   parameter int PF      = 4,
   parameter int EW      = 8,
   parameter int ROW_MAX = 16,
   localparam int CW     = 2 * EW,
   localparam int DW     = PF * CW,
   localparam int PW     = 2 * EW + 1,
   localparam int ACC_W  = PW + $clog2(PF * ROW_MAX) + 1,
   localparam int SH_W   = $clog2(ACC_W + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      cfg_op,
   input logic            cfg_reduce,
   input logic            cfg_alpha_ind,
   input logic            cfg_same,
   input logic [CW-1:0]   cfg_alpha,
   input logic            cfg_round,
   input logic            cfg_sat,
   input logic [SH_W-1:0] cfg_shift,
   input logic            in_valid,
   input logic            in_ready,
   input logic [DW-1:0]   in_a,
   input logic [DW-1:0]   in_b,
   input logic [CW-1:0]   in_alpha,
   input logic            in_last,
   input logic            out_valid,
   input logic            out_ready,
   input logic [DW-1:0]   out_data,
   input logic            out_last
);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   p_red_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cfg_reduce |-> out_last && ((out_data >> CW) == '0));

   p_red_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && cfg_reduce && !in_last |=> !out_valid);

   p_beat_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !cfg_reduce |=> out_valid && (out_last == $past(in_last)));

   p_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);
endmodule

bind cvmac_engine cvmac_engine_chk #(.PF(PF), .EW(EW), .ROW_MAX(ROW_MAX)) u_chk (.*);

// File: tb/cvmac_engine_bench.sv
module cvmac_engine_bench;
   localparam int PF = 4;
   localparam int DW = PF * 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]  cfg_op = '0;
   logic        cfg_reduce = 1'b0, cfg_alpha_ind = 1'b0, cfg_same = 1'b0;
   logic [15:0] cfg_alpha = '0;
   logic        cfg_round = 1'b0, cfg_sat = 1'b0;
   logic [4:0]  cfg_shift = '0;
   logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
   logic [DW-1:0] in_a = '0, in_b = '0;
   logic [15:0] in_alpha = '0;
   logic        in_ready, out_valid, out_last;
   logic [DW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   longint acc_re, acc_im;

   always #5 clk = ~clk;

   cvmac_engine u_cvmac_engine (.*);

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic longint sx(logic [7:0] v);
      return longint'($signed(v));
   endfunction

   function automatic logic [7:0] qz(longint v, int s, bit r, bit sat);
      longint t = v;
      if (r && s > 0) t = t + (longint'(1) << (s - 1));
      t = t >>> s;
      if (sat && t > 127)  return 8'h7f;
      if (sat && t < -128) return 8'h80;
      return t[7:0];
   endfunction

   function automatic void lane_val(int op, logic [15:0] a, logic [15:0] b,
                                    logic [15:0] al, output longint re, output longint im);
      longint xr, xi, yr, yi;
      if (op == 2) begin
         re = sx(a[7:0]) + sx(b[7:0]);
         im = sx(a[15:8]) + sx(b[15:8]);
         return;
      end
      xr = (op == 0) ? sx(al[7:0])  : sx(a[7:0]);
      xi = (op == 0) ? sx(al[15:8]) : sx(a[15:8]);
      yr = (op == 0) ? sx(a[7:0])   : sx(b[7:0]);
      yi = (op == 0) ? sx(a[15:8])  : sx(b[15:8]);
      re = xr * yr - xi * yi;
      im = xr * yi + xi * yr;
   endfunction

   // Expected per-beat word; also accumulates into acc_re/acc_im.
   function automatic logic [DW-1:0] model(logic [DW-1:0] a, logic [DW-1:0] b, logic [15:0] al);
      logic [DW-1:0] w;
      longint re, im;
      for (int k = 0; k < PF; k++) begin
         lane_val(int'(cfg_op), a[k*16 +: 16], b[k*16 +: 16], al, re, im);
         acc_re += re;
         acc_im += im;
         w[k*16 +: 16] = {qz(im, int'(cfg_shift), cfg_round, cfg_sat),
                          qz(re, int'(cfg_shift), cfg_round, cfg_sat)};
      end
      return w;
   endfunction

   function automatic logic [DW-1:0] red_exp();
      logic [DW-1:0] w = '0;
      w[15:0] = {qz(acc_im, int'(cfg_shift), cfg_round, cfg_sat),
                 qz(acc_re, int'(cfg_shift), cfg_round, cfg_sat)};
      return w;
   endfunction

   task automatic set_cfg(int op, bit red, bit ind, bit same, logic [15:0] al,
                          bit r, bit sat, int sh);
      @(posedge clk);
      @(negedge clk);
      cfg_op = 2'(op); cfg_reduce = red; cfg_alpha_ind = ind; cfg_same = same;
      cfg_alpha = al; cfg_round = r; cfg_sat = sat; cfg_shift = 5'(sh);
      acc_re = 0; acc_im = 0;
   endtask

   task automatic beat(logic [DW-1:0] a, logic [DW-1:0] b, logic [15:0] al, bit last);
      @(negedge clk);
      in_a = a; in_b = b; in_alpha = al; in_last = last; in_valid = 1'b1;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   function automatic logic [DW-1:0] rnd_word();
      return {$urandom, $urandom};
   endfunction

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] a, b, e;
      logic [15:0] al, al0;
      int shifts [3] = '{0, 2, 5};
      void'($urandom(32'h5eed));

      // R11: reset state
      #1;
      chk("R11 out_valid in reset", DW'(out_valid), '0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R11 out_valid after reset", DW'(out_valid), '0);
      chk("R11 in_ready after reset", DW'(in_ready), DW'(1));

      // Sweep: element-wise, all ops and quantisation modes (R1,R2,R3,R5,R8,R9,R12)
      for (int op = 0; op < 3; op++)
         for (int r = 0; r < 2; r++)
            for (int si = 0; si < 3; si++)
               for (int sat = 0; sat < 2; sat++) begin
                  al = $urandom;
                  set_cfg(op, 0, 0, 0, al, r[0], sat[0], shifts[si]);
                  for (int t = 0; t < 3; t++) begin
                     a = rnd_word(); b = rnd_word();
                     e = model(a, b, al);
                     beat(a, b, 16'(~al), t == 2);
                     chk(op == 0 ? "R1 scale lanes" : op == 1 ? "R2 product lanes" : "R3 sum lanes",
                         out_data, e);
                     chk("R5 valid/last per beat", DW'({out_valid, out_last}), DW'({1'b1, t == 2}));
                     chk("R12 in_ready stays high", DW'(in_ready), DW'(1));
                  end
               end

      // Reduce sweep (R4, R8, R9)
      for (int op = 0; op < 3; op++)
         for (int r = 0; r < 2; r++)
            for (int si = 0; si < 3; si++)
               for (int sat = 0; sat < 2; sat++) begin
                  al = $urandom;
                  set_cfg(op, 1, 0, 0, al, r[0], sat[0], shifts[si] + 2);
                  for (int t = 0; t < 4; t++) begin
                     a = rnd_word(); b = rnd_word();
                     e = model(a, b, al);
                     beat(a, b, al, t == 3);
                     if (t < 3) chk("R4 no output mid-row", DW'(out_valid), '0);
                     else begin
                        chk("R4 reduced word", out_data, red_exp());
                        chk("R4 reduced last", DW'({out_valid, out_last}), DW'(3));
                     end
                  end
               end

      // R9 boundary: (-128-128j)^2 = 0 + 32768j
      set_cfg(1, 0, 0, 0, '0, 0, 1, 0);
      beat({PF{16'h8080}}, {PF{16'h8080}}, '0, 1);
      chk("R9 saturate high", out_data, {PF{16'h7f00}});
      set_cfg(1, 0, 0, 0, '0, 0, 0, 0);
      beat({PF{16'h8080}}, {PF{16'h8080}}, '0, 1);
      chk("R9 wrap", out_data, {PF{16'h0000}});
      set_cfg(2, 0, 0, 0, '0, 0, 1, 0);
      beat({PF{16'h8080}}, {PF{16'h8080}}, '0, 1);
      chk("R9 saturate low", out_data, {PF{16'h8080}});
      // R8 boundary: 3 >> 1 truncates to 1, rounds to 2; -3 rounds to -1
      set_cfg(2, 0, 0, 0, '0, 0, 0, 1);
      beat({PF{16'hfe01}}, {PF{16'hff02}}, '0, 1);
      chk("R8 truncate", out_data, {PF{16'hfe01}});
      set_cfg(2, 0, 0, 0, '0, 1, 0, 1);
      beat({PF{16'hfe01}}, {PF{16'hff02}}, '0, 1);
      chk("R8 round half up", out_data, {PF{16'hff02}});

      // R6 indirect alpha: first beat's in_alpha used for the whole row
      for (int red = 0; red < 2; red++) begin
         set_cfg(0, red[0], 1, 0, 16'h0101, 0, 0, 4);
         for (int row = 0; row < 2; row++) begin
            al0 = $urandom;
            acc_re = 0; acc_im = 0;
            for (int t = 0; t < 3; t++) begin
               a = rnd_word();
               e = model(a, '0, al0);
               beat(a, rnd_word(), t == 0 ? al0 : 16'($urandom), t == 2);
               if (red == 0) chk("R6 indirect alpha per row", out_data, e);
               else if (t == 2) chk("R6 indirect alpha reduced", out_data, red_exp());
            end
         end
      end
      // R6 direct alpha: in_alpha ignored
      al = 16'h03fd;
      set_cfg(0, 0, 0, 0, al, 1, 1, 2);
      a = rnd_word();
      e = model(a, '0, al);
      beat(a, '0, 16'h7f7f, 1);
      chk("R6 direct alpha", out_data, e);

      // R7 same operand: in_b ignored
      set_cfg(1, 1, 0, 1, '0, 1, 1, 6);
      for (int t = 0; t < 3; t++) begin
         a = rnd_word();
         e = model(a, a, '0);
         beat(a, rnd_word(), '0, t == 2);
      end
      chk("R7 same-operand reduced", out_data, red_exp());
      set_cfg(2, 0, 0, 1, '0, 0, 0, 0);
      a = rnd_word();
      e = model(a, a, '0);
      beat(a, ~a, '0, 1);
      chk("R7 same-operand sum", out_data, e);

      // R10 backpressure
      set_cfg(2, 0, 0, 0, '0, 0, 0, 0);
      @(negedge clk); out_ready = 1'b0;
      a = rnd_word(); b = rnd_word();
      e = model(a, b, '0);
      beat(a, b, '0, 0);
      chk("R10 first word", out_data, e);
      @(negedge clk);
      in_a = rnd_word(); in_b = rnd_word(); in_last = 1'b1; in_valid = 1'b1;
      a = in_a; b = in_b;
      @(posedge clk); #1;
      chk("R10 held data", out_data, e);
      chk("R10 in_ready low", DW'({in_ready, out_valid, out_last}), DW'(3'b010));
      @(negedge clk); out_ready = 1'b1;
      e = model(a, b, '0);
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk("R10 released beat", out_data, e);
      chk("R10 released last", DW'({out_valid, out_last}), DW'(3));
      @(posedge clk); #1;
      chk("R12 idle after drain", DW'(out_valid), '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule